// File: doc/BRIEF.md
# Pointer Register Hazard Interlock

This block guards indirect addressing in a five-stage in-order pipeline whose stages run DECODE, ADDRESS, MEMORY, EXECUTE, WRITE-BACK. An instruction computes its indirect address in ADDRESS, two stages ahead of the stage that produces register results. A register value that an older instruction has not finished computing cannot be used as a pointer yet. The block keeps the destination tags of the instructions in flight. It detects a pointer register that still has a pending write in MEMORY or EXECUTE. It then holds DECODE and ADDRESS and drops a bubble into MEMORY until the producer has left EXECUTE.

Once the producer has reached WRITE-BACK, its EXECUTE result is forwarded back to address generation. Older values come from a 16-entry register file that the block writes from WRITE-BACK. A producer followed by two single-cycle instructions, or by one instruction that takes two cycles in ADDRESS, therefore costs no hazard stall. The upstream fetch logic must hold its instruction on the inputs while `stall` is high. The execution unit reads `ex_wr`/`ex_wdst` and returns the result on `ex_result` in the same cycle.

Top module: `ptr_hazard_unit`

## Requirements
- R1: After reset, `stall`, `mem_bubble` and `ptr_valid` are 0.
- R2: A pointer use that directly follows its producer (no instruction in between) gives exactly 2 stall cycles.
- R3: A pointer use with one single-cycle instruction between it and its producer gives exactly 1 stall cycle.
- R4: With two single-cycle instructions in between, there is no stall. The pointer value is the producer's EXECUTE result, forwarded (`ptr_fwd`=1).
- R5: With three or more instructions in between, there is no stall. The pointer value comes from the register file (`ptr_fwd`=0).
- R6: An instruction with `in_multi`=1 stays in ADDRESS for two cycles, which costs 1 stall cycle. One such instruction between producer and pointer use removes the hazard stall, so the sequence costs only that 1 cycle.
- R7: An instruction with `in_we`=0 or `in_valid`=0 causes no hazard, whatever its `in_dst` is. Pending writes to other registers also cause none.
- R8: Every stall cycle is followed by `mem_bubble`=1 in the next cycle. `mem_bubble` is 1 only after a stall cycle.
- R9: When several in-flight instructions write the pointer register, the value used is the result of the youngest of them.
- R10: `ptr_valid` pulses once, in the cycle after the pointer use leaves ADDRESS unstalled, and carries `ptr_val`/`ptr_fwd`. An instruction with `in_ptr_use`=0 produces no pulse and no stall.
- R11: `stall` never stays high for more than 2 consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction entering DECODE is valid |
| in_we | input | 1 | Instruction writes a register |
| in_dst | input | IDX_W | Destination register index |
| in_ptr_use | input | 1 | Instruction uses a register as an indirect pointer |
| in_ptr | input | IDX_W | Pointer register index |
| in_multi | input | 1 | Instruction occupies ADDRESS for two cycles |
| ex_result | input | DATA_W | Result of the instruction now in EXECUTE |
| stall | output | 1 | Hold DECODE input and ADDRESS this cycle |
| mem_bubble | output | 1 | MEMORY holds an injected bubble |
| ex_wr | output | 1 | EXECUTE holds a valid register-writing instruction |
| ex_wdst | output | IDX_W | Destination of the instruction in EXECUTE |
| ptr_valid | output | 1 | A pointer operand was issued last cycle |
| ptr_val | output | DATA_W | Pointer operand value |
| ptr_fwd | output | 1 | Operand came from the forwarded result |

## Verification
Producer and pointer use are run with zero, one, two and three single-cycle instructions between them. These tell apart a 2-cycle stall, a 1-cycle stall, a stall-free forward and a stall-free register-file read. In further runs the fillers are swapped for a two-cycle instruction, and then for write-disabled instructions naming the pointer register. These show that only a real pending write stalls. Two writers to one register separate youngest-first forwarding from reads of stale state. A non-pointer instruction that names a pending register must pass with no stall and no operand pulse.

// File: rtl/ptr_hazard_pkg.sv
package ptr_hazard_pkg;
  localparam int ST_DEC  = 0;
  localparam int ST_ADR  = 1;
  localparam int ST_MEM  = 2;
  localparam int ST_EXE  = 3;
  localparam int ST_WB   = 4;
  localparam int NUM_ST  = ST_WB + 1;
  // stages whose pending write blocks a pointer read in ADDRESS
  localparam int NUM_CHK = ST_EXE - ST_MEM + 1;
endpackage

// File: rtl/ptr_hazard_pipe.sv
module ptr_hazard_pipe
  import ptr_hazard_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic              in_valid,
  input  logic              in_we,
  input  logic [IDX_W-1:0]  in_dst,
  input  logic              in_ptr_use,
  input  logic [IDX_W-1:0]  in_ptr,
  input  logic              in_multi,
  input  logic [DATA_W-1:0] ex_result,
  output logic              a_valid,
  output logic              a_ptr_use,
  output logic [IDX_W-1:0]  a_ptr,
  output logic              a_multi,
  output logic              chk_valid [NUM_CHK],
  output logic              chk_we    [NUM_CHK],
  output logic [IDX_W-1:0]  chk_dst   [NUM_CHK],
  output logic              wb_valid,
  output logic              wb_we,
  output logic [IDX_W-1:0]  wb_dst,
  output logic [DATA_W-1:0] wb_res
);
  logic             sv   [NUM_ST];
  logic             swe  [NUM_ST];
  logic [IDX_W-1:0] sdst [NUM_ST];
  logic             d_pu, q_pu;
  logic [IDX_W-1:0] d_ptr, q_ptr;
  logic             d_mc, q_mc;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_ST; i++) begin
        sv[i]   <= 1'b0;
        swe[i]  <= 1'b0;
        sdst[i] <= '0;
      end
      d_pu   <= 1'b0;
      q_pu   <= 1'b0;
      d_ptr  <= '0;
      q_ptr  <= '0;
      d_mc   <= 1'b0;
      q_mc   <= 1'b0;
      wb_res <= '0;
    end else begin
      if (!hold) begin
        sv[ST_DEC]   <= in_valid;
        swe[ST_DEC]  <= in_we;
        sdst[ST_DEC] <= in_dst;
        d_pu         <= in_ptr_use;
        d_ptr        <= in_ptr;
        d_mc         <= in_multi;
        sv[ST_ADR]   <= sv[ST_DEC];
        swe[ST_ADR]  <= swe[ST_DEC];
        sdst[ST_ADR] <= sdst[ST_DEC];
        q_pu         <= d_pu;
        q_ptr        <= d_ptr;
        q_mc         <= d_mc;
        sv[ST_MEM]   <= sv[ST_ADR];
        swe[ST_MEM]  <= swe[ST_ADR];
        sdst[ST_MEM] <= sdst[ST_ADR];
      end else begin
        sv[ST_MEM]   <= 1'b0;
        swe[ST_MEM]  <= 1'b0;
      end
      for (int i = ST_EXE; i < NUM_ST; i++) begin
        sv[i]   <= sv[i-1];
        swe[i]  <= swe[i-1];
        sdst[i] <= sdst[i-1];
      end
      if (sv[ST_EXE] && swe[ST_EXE])
        wb_res <= ex_result;
    end
  end

  assign a_valid   = sv[ST_ADR];
  assign a_ptr_use = q_pu;
  assign a_ptr     = q_ptr;
  assign a_multi   = q_mc;

  for (genvar g = 0; g < NUM_CHK; g++) begin : g_chk
    assign chk_valid[g] = sv[ST_MEM+g];
    assign chk_we[g]    = swe[ST_MEM+g];
    assign chk_dst[g]   = sdst[ST_MEM+g];
  end

  assign wb_valid = sv[ST_WB];
  assign wb_we    = swe[ST_WB];
  assign wb_dst   = sdst[ST_WB];
endmodule

// File: rtl/ptr_hazard_detect.sv
module ptr_hazard_detect
  import ptr_hazard_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             a_valid,
  input  logic             a_ptr_use,
  input  logic [IDX_W-1:0] a_ptr,
  input  logic             a_multi,
  input  logic             chk_valid [NUM_CHK],
  input  logic             chk_we    [NUM_CHK],
  input  logic [IDX_W-1:0] chk_dst   [NUM_CHK],
  output logic             hold
);
  logic [NUM_CHK-1:0] match;
  logic               ptr_hazard;
  logic               multi_hold;
  logic               multi_done;

  for (genvar g = 0; g < NUM_CHK; g++) begin : g_cmp
    assign match[g] = chk_valid[g] && chk_we[g] && (chk_dst[g] == a_ptr);
  end

  assign ptr_hazard = a_valid && a_ptr_use && (|match);
  assign multi_hold = a_valid && a_multi && !multi_done;
  assign hold       = ptr_hazard || multi_hold;

  always_ff @(posedge clk) begin
    if (rst)
      multi_done <= 1'b0;
    else if (!hold)
      multi_done <= 1'b0;
    else if (multi_hold)
      multi_done <= 1'b1;
  end
endmodule

// File: rtl/ptr_hazard_rf.sv
module ptr_hazard_rf #(
  parameter int IDX_W  = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en)
      mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/ptr_hazard_opsel.sv
module ptr_hazard_opsel #(
  parameter int IDX_W  = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic              a_valid,
  input  logic              a_ptr_use,
  input  logic [IDX_W-1:0]  a_ptr,
  input  logic              wb_valid,
  input  logic              wb_we,
  input  logic [IDX_W-1:0]  wb_dst,
  input  logic [DATA_W-1:0] wb_res,
  input  logic [DATA_W-1:0] rf_data,
  output logic              ptr_valid,
  output logic [DATA_W-1:0] ptr_val,
  output logic              ptr_fwd,
  output logic              mem_bubble
);
  logic              sel_fwd;
  logic              issue;
  logic [DATA_W-1:0] operand;

  always_comb begin
    sel_fwd = wb_valid && wb_we && (wb_dst == a_ptr);
    operand = sel_fwd ? wb_res : rf_data;
    issue   = a_valid && a_ptr_use && !hold;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_valid  <= 1'b0;
      ptr_val    <= '0;
      ptr_fwd    <= 1'b0;
      mem_bubble <= 1'b0;
    end else begin
      ptr_valid  <= issue;
      mem_bubble <= hold;
      if (issue) begin
        ptr_val <= operand;
        ptr_fwd <= sel_fwd;
      end
    end
  end
endmodule

// File: rtl/ptr_hazard_unit.sv
module ptr_hazard_unit
  import ptr_hazard_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_we,
  input  logic [IDX_W-1:0]  in_dst,
  input  logic              in_ptr_use,
  input  logic [IDX_W-1:0]  in_ptr,
  input  logic              in_multi,
  input  logic [DATA_W-1:0] ex_result,
  output logic              stall,
  output logic              mem_bubble,
  output logic              ex_wr,
  output logic [IDX_W-1:0]  ex_wdst,
  output logic              ptr_valid,
  output logic [DATA_W-1:0] ptr_val,
  output logic              ptr_fwd
);
  localparam int EX_SLOT = ST_EXE - ST_MEM;

  logic              hold;
  logic              a_valid, a_ptr_use, a_multi;
  logic [IDX_W-1:0]  a_ptr;
  logic              chk_valid [NUM_CHK];
  logic              chk_we    [NUM_CHK];
  logic [IDX_W-1:0]  chk_dst   [NUM_CHK];
  logic              wb_valid, wb_we;
  logic [IDX_W-1:0]  wb_dst;
  logic [DATA_W-1:0] wb_res;
  logic [DATA_W-1:0] rf_data;

  ptr_hazard_pipe #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_pipe (
    .clk(clk), .rst(rst), .hold(hold),
    .in_valid(in_valid), .in_we(in_we), .in_dst(in_dst),
    .in_ptr_use(in_ptr_use), .in_ptr(in_ptr), .in_multi(in_multi),
    .ex_result(ex_result),
    .a_valid(a_valid), .a_ptr_use(a_ptr_use), .a_ptr(a_ptr), .a_multi(a_multi),
    .chk_valid(chk_valid), .chk_we(chk_we), .chk_dst(chk_dst),
    .wb_valid(wb_valid), .wb_we(wb_we), .wb_dst(wb_dst), .wb_res(wb_res)
  );

  ptr_hazard_detect #(.IDX_W(IDX_W)) u_detect (
    .clk(clk), .rst(rst),
    .a_valid(a_valid), .a_ptr_use(a_ptr_use), .a_ptr(a_ptr), .a_multi(a_multi),
    .chk_valid(chk_valid), .chk_we(chk_we), .chk_dst(chk_dst),
    .hold(hold)
  );

  ptr_hazard_rf #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_rf (
    .clk(clk), .wr_en(wb_valid && wb_we), .wr_addr(wb_dst), .wr_data(wb_res),
    .rd_addr(a_ptr), .rd_data(rf_data)
  );

  ptr_hazard_opsel #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_opsel (
    .clk(clk), .rst(rst), .hold(hold),
    .a_valid(a_valid), .a_ptr_use(a_ptr_use), .a_ptr(a_ptr),
    .wb_valid(wb_valid), .wb_we(wb_we), .wb_dst(wb_dst), .wb_res(wb_res),
    .rf_data(rf_data),
    .ptr_valid(ptr_valid), .ptr_val(ptr_val), .ptr_fwd(ptr_fwd),
    .mem_bubble(mem_bubble)
  );

  assign stall   = hold;
  assign ex_wr   = chk_valid[EX_SLOT] && chk_we[EX_SLOT];
  assign ex_wdst = chk_dst[EX_SLOT];
endmodule

// File: rtl/ptr_hazard_unit_chk.sv
module ptr_hazard_unit_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             stall,
  input logic             mem_bubble,
  input logic             ptr_valid,
  input logic             ex_wr,
  input logic [IDX_W-1:0] ex_wdst,
  input logic             a_valid,
  input logic             a_ptr_use,
  input logic [IDX_W-1:0] a_ptr
);
  logic [2:0] run;

  always_ff @(posedge clk) begin
    if (rst)
      run <= '0;
    else if (stall && run != 3'd7)
      run <= run + 3'd1;
    else if (!stall)
      run <= '0;
  end

  assert_exe_hazard_stall_R2: assert property (@(posedge clk) disable iff (rst)
    (a_valid && a_ptr_use && ex_wr && ex_wdst == a_ptr) |-> stall);

  assert_bubble_after_stall_R8: assert property (@(posedge clk) disable iff (rst)
    stall |=> mem_bubble);

  assert_bubble_cause_R8: assert property (@(posedge clk) disable iff (rst)
    mem_bubble |-> $past(stall));

  assert_issue_unstalled_R10: assert property (@(posedge clk) disable iff (rst)
    ptr_valid |-> !$past(stall));

  assert_stall_run_R11: assert property (@(posedge clk) disable iff (rst)
    stall |-> (run < 3'd2));
endmodule

bind ptr_hazard_unit ptr_hazard_unit_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .stall(stall), .mem_bubble(mem_bubble),
  .ptr_valid(ptr_valid), .ex_wr(ex_wr), .ex_wdst(ex_wdst),
  .a_valid(a_valid), .a_ptr_use(a_ptr_use), .a_ptr(a_ptr)
);

// File: tb/ptr_hazard_unit_tb_top.sv
module ptr_hazard_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W      = 4;
  localparam int DATA_W     = 16;
  localparam int NVEC       = 6;
  // [15:12] reg, [11:10] fillers, [9] two-cycle filler, [8] write-disabled fillers,
  // [7:6] expected stalls, [5] expected forward
  localparam logic [15:0] VEC [NVEC] = '{
    {4'd1, 2'd0, 1'b0, 1'b0, 2'd2, 1'b1, 5'd0},
    {4'd2, 2'd1, 1'b0, 1'b0, 2'd1, 1'b1, 5'd0},
    {4'd3, 2'd2, 1'b0, 1'b0, 2'd0, 1'b1, 5'd0},
    {4'd4, 2'd3, 1'b0, 1'b0, 2'd0, 1'b0, 5'd0},
    {4'd5, 2'd1, 1'b1, 1'b0, 2'd1, 1'b1, 5'd0},
    {4'd6, 2'd2, 1'b0, 1'b1, 2'd0, 1'b1, 5'd0}
  };

  logic clk = 1'b0;
  logic rst;
  logic in_valid, in_we, in_ptr_use, in_multi;
  logic [IDX_W-1:0] in_dst, in_ptr;
  logic [DATA_W-1:0] ex_result;
  logic stall, mem_bubble, ex_wr, ptr_valid, ptr_fwd;
  logic [IDX_W-1:0] ex_wdst;
  logic [DATA_W-1:0] ptr_val;
  logic [DATA_W-IDX_W-1:0] wcnt;

  int n_chk = 0, n_fail = 0;
  int stalls, run, maxrun = 0, pv_cnt, bub_cnt, wr_issued = 0;
  int last_val, last_fwd;
  int exp_reg [16];
  bit done = 0;

  ptr_hazard_unit #(.IDX_W(IDX_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_we(in_we), .in_dst(in_dst),
    .in_ptr_use(in_ptr_use), .in_ptr(in_ptr), .in_multi(in_multi),
    .ex_result(ex_result), .stall(stall), .mem_bubble(mem_bubble),
    .ex_wr(ex_wr), .ex_wdst(ex_wdst), .ptr_valid(ptr_valid),
    .ptr_val(ptr_val), .ptr_fwd(ptr_fwd)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // execution unit model: k-th register write returns {k, dst}
  always @(posedge clk) begin
    if (rst) wcnt <= '0;
    else if (ex_wr) wcnt <= wcnt + 1'b1;
  end
  assign ex_result = {wcnt, ex_wdst};

  always @(posedge clk) begin
    #2;
    if (ptr_valid) begin
      pv_cnt++;
      last_val = int'(ptr_val);
      last_fwd = int'(ptr_fwd);
    end
    if (mem_bubble) bub_cnt++;
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input bit v, input bit we, input int dst, input bit pu,
                      input int ptr, input bit mc);
    in_valid = v; in_we = we; in_dst = dst[IDX_W-1:0];
    in_ptr_use = pu; in_ptr = ptr[IDX_W-1:0]; in_multi = mc;
    forever begin
      if (stall) begin
        stalls++; run++;
        if (run > maxrun) maxrun = run;
        @(negedge clk);
      end else begin
        run = 0;
        @(negedge clk);
        break;
      end
    end
    if (v && we) begin
      exp_reg[dst] = ((wr_issued << IDX_W) | dst) & 16'hFFFF;
      wr_issued++;
    end
  endtask

  task automatic seq_begin();
    stalls = 0; pv_cnt = 0; bub_cnt = 0;
  endtask

  task automatic drain();
    for (int i = 0; i < 6; i++) push(0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    in_valid = 0; in_we = 0; in_dst = 0; in_ptr_use = 0; in_ptr = 0; in_multi = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1
    check("R1 stall", int'(stall), 0);
    check("R1 mem_bubble", int'(mem_bubble), 0);
    check("R1 ptr_valid", int'(ptr_valid), 0);

    for (int k = 0; k < NVEC; k++) begin
      int r, gap, exs, exf;
      bit mc, ro;
      string tg;
      r = int'(VEC[k][15:12]); gap = int'(VEC[k][11:10]);
      mc = VEC[k][9]; ro = VEC[k][8];
      exs = int'(VEC[k][7:6]); exf = int'(VEC[k][5]);
      if (mc) tg = "R6";
      else if (ro) tg = "R7";
      else if (gap == 0) tg = "R2";
      else if (gap == 1) tg = "R3";
      else if (gap == 2) tg = "R4";
      else tg = "R5";
      seq_begin();
      push(1, 1, r, 0, 0, 0);
      for (int f = 0; f < gap; f++) begin
        if (ro) push(1, 0, r, 0, 0, 0);
        else push(1, 1, r ^ 8, 0, 0, mc);
      end
      push(1, 0, 0, 1, r, 0);
      drain();
      check({tg, " stall cycles"}, stalls, exs);
      check({tg, " pointer value"}, last_val, exp_reg[r]);
      check({tg, " forward flag"}, last_fwd, exf);
      check("R10 single operand pulse", pv_cnt, 1);
      check("R8 bubbles match stalls", bub_cnt, stalls);
    end

    // R9: two writers, two fillers, then pointer use
    seq_begin();
    push(1, 1, 7, 0, 0, 0);
    push(1, 1, 7, 0, 0, 0);
    push(1, 1, 15, 0, 0, 0);
    push(1, 1, 15, 0, 0, 0);
    push(1, 0, 0, 1, 7, 0);
    drain();
    check("R9 youngest stalls", stalls, 0);
    check("R9 youngest value", last_val, exp_reg[7]);
    check("R9 youngest forward", last_fwd, 1);

    // R9: two writers directly ahead of the pointer use
    seq_begin();
    push(1, 1, 11, 0, 0, 0);
    push(1, 1, 11, 0, 0, 0);
    push(1, 0, 0, 1, 11, 0);
    drain();
    check("R9 back-to-back stalls", stalls, 2);
    check("R9 back-to-back value", last_val, exp_reg[11]);

    // R10: non-pointer instruction naming a pending register
    seq_begin();
    push(1, 1, 12, 0, 0, 0);
    push(1, 0, 0, 0, 12, 0);
    drain();
    check("R10 non-pointer stalls", stalls, 0);
    check("R10 non-pointer pulses", pv_cnt, 0);

    // R6: two-cycle instruction alone
    seq_begin();
    push(1, 0, 0, 0, 0, 1);
    drain();
    check("R6 two-cycle alone stalls", stalls, 1);
    check("R8 two-cycle bubble", bub_cnt, 1);

    // R7: invalid slot carrying a write tag directly ahead of a pointer use
    seq_begin();
    push(0, 1, 3, 0, 0, 0);
    push(1, 0, 0, 1, 3, 0);
    drain();
    check("R7 invalid writer stalls", stalls, 0);
    check("R7 invalid writer value", last_val, exp_reg[3]);

    check("R11 longest stall run", (maxrun <= 2) ? 1 : 0, 1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule